// File: doc/BRIEF.md
# Condition Flag and Branch Resolver

This block keeps the three sign flags of a 16-bit processor and decides where execution goes after a conditional branch. When the control unit asserts a load strobe, the block samples the value on the shared result bus and records it as negative, zero or positive. The strobe is raised only for instructions that write a register. Exactly one of the three flags is set at any time.

When the branch-evaluate strobe is high, the block reads a three-bit condition mask and a nine-bit page offset from the instruction word. It reports the branch as taken if any flag named by the mask is currently set. A taken branch goes to a target built from the upper seven bits of the PC and the page offset, so the target stays inside the current 512-word page. Otherwise the next PC is PC+1. The branch outputs are combinational and use the flag state held before the current clock edge. The PC register, bus drivers and other instruction decode sit outside the block.

Top module: `flag_branch_resolver`

## Requirements
- R1: After reset, and before any load, the flag output `flagsOut` reads 3'b010. Bit 2 is negative, bit 1 is zero and bit 0 is positive.
- R2: On a clock edge with `loadFlags` high, `flagsOut` takes one of three values. It becomes 3'b100 if bit 15 of `busValue` is set, 3'b010 if `busValue` is zero, and 3'b001 otherwise.
- R3: On a clock edge with `loadFlags` low, `flagsOut` keeps its value, whatever `busValue` holds.
- R4: `flagsOut` always has exactly one bit set.
- R5: With `branchEval` high, `branchTaken` is the OR of (mask AND flags). The mask is `instr[11:9]`: bit 11 selects negative, bit 10 selects zero and bit 9 selects positive.
- R6: When `branchTaken` is high, `nextPc` equals {`pcValue[15:9]`, `instr[8:0]`}.
- R7: When `branchTaken` is low, `nextPc` equals `pcValue`+1 modulo 2^16, so 16'hFFFF wraps to 16'h0000.
- R8: With `branchEval` high, a mask of 3'b000 never takes the branch and a mask of 3'b111 always takes it.
- R9: With `branchEval` low, `branchTaken` is 0 and `nextPc` is `pcValue`+1, whatever the mask and flags are.
- R10: A branch evaluated in the same cycle as a flag load uses the flags held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValue | input | 16 | Value on the result bus that is classified for the flags |
| loadFlags | input | 1 | Load-flags enable from the control unit |
| instr | input | 16 | Instruction word; bits 11:9 are the mask and bits 8:0 are the page offset |
| pcValue | input | 16 | Current program counter |
| branchEval | input | 1 | Branch-evaluate strobe |
| branchTaken | output | 1 | The branch is taken |
| nextPc | output | 16 | Selected next PC: the in-page target or PC+1 |
| flagsOut | output | 3 | Current flags {negative, zero, positive} |

## Verification
The bench builds the block with its default widths: a 16-bit datapath and a 9-bit page offset. These widths are small enough to sweep all eight masks, with the strobe both high and low, against every flag state. The sweep runs over many bus values, including the sign boundaries 16'h7FFF and 16'h8000 and zero. It also uses a PC of 16'hFFFF, which exercises the increment wrap and the page splice at the top of the address space.

// File: rtl/flag_branch_pkg.sv
package flag_branch_pkg;

  // Sign flags, packed so that bit 2 = negative, bit 1 = zero, bit 0 = positive
  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } flags_t;

  // Strobes issued by the control half to the datapath
  typedef struct packed {
    logic captureFlags;
    logic resolveBranch;
  } branch_ctrl_t;

  localparam flags_t FLAGS_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};

endpackage

// File: rtl/flag_branch_ctrl.sv
module flag_branch_ctrl
  import flag_branch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 9
) (
  input  logic              loadFlags,
  input  logic              branchEval,
  input  logic [DATA_W-1:0] instr,
  output branch_ctrl_t      ctrl,
  output logic [2:0]        condMask,
  output logic [PAGE_W-1:0] pageOffset
);

  localparam int MASK_LSB = PAGE_W;
  localparam int MASK_MSB = PAGE_W + 2;

  // Field extraction: the mask sits directly above the page offset
  assign condMask   = instr[MASK_MSB:MASK_LSB];
  assign pageOffset = instr[PAGE_W-1:0];

  always_comb begin
    ctrl               = '0;
    ctrl.captureFlags  = loadFlags;
    ctrl.resolveBranch = branchEval;
  end

endmodule

// File: rtl/flag_branch_datapath.sv
module flag_branch_datapath
  import flag_branch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  branch_ctrl_t      ctrl,
  input  logic [DATA_W-1:0] busValue,
  input  logic [2:0]        condMask,
  input  logic [PAGE_W-1:0] pageOffset,
  input  logic [DATA_W-1:0] pcValue,
  output flags_t            flags,
  output logic              branchTaken,
  output logic [DATA_W-1:0] nextPc
);

  localparam int PAGE_NUM_W = DATA_W - PAGE_W;
  localparam int NUM_FLAGS  = 3;

  flags_t                 signClass;
  logic [NUM_FLAGS-1:0]   flagVec;
  logic [NUM_FLAGS-1:0]   hitVec;
  logic [DATA_W-1:0]      pcInc;
  logic [DATA_W-1:0]      pageTarget;
  logic [PAGE_NUM_W-1:0]  pageNum;

  // Classify the bus value into exactly one sign class
  always_comb begin
    signClass = '0;
    if (busValue[DATA_W-1])       signClass.neg  = 1'b1;
    else if (busValue == '0)      signClass.zero = 1'b1;
    else                          signClass.pos  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flags <= FLAGS_RESET;
    else if (ctrl.captureFlags) flags <= signClass;
  end

  assign flagVec = flags;

  // Per-flag mask match
  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_match
    assign hitVec[k] = condMask[k] & flagVec[k];
  end

  assign branchTaken = ctrl.resolveBranch & (|hitVec);

  assign pageNum    = pcValue[DATA_W-1:PAGE_W];
  assign pageTarget = {pageNum, pageOffset};
  assign pcInc      = pcValue + DATA_W'(1);
  assign nextPc     = branchTaken ? pageTarget : pcInc;

endmodule

// File: rtl/flag_branch_resolver.sv
module flag_branch_resolver
  import flag_branch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busValue,
  input  logic              loadFlags,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pcValue,
  input  logic              branchEval,
  output logic              branchTaken,
  output logic [DATA_W-1:0] nextPc,
  output logic [2:0]        flagsOut
);

  branch_ctrl_t      ctrl;
  logic [2:0]        condMask;
  logic [PAGE_W-1:0] pageOffset;
  flags_t            flags;

  flag_branch_ctrl #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) uCtrl (
    .loadFlags  (loadFlags),
    .branchEval (branchEval),
    .instr      (instr),
    .ctrl       (ctrl),
    .condMask   (condMask),
    .pageOffset (pageOffset)
  );

  flag_branch_datapath #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .busValue    (busValue),
    .condMask    (condMask),
    .pageOffset  (pageOffset),
    .pcValue     (pcValue),
    .flags       (flags),
    .branchTaken (branchTaken),
    .nextPc      (nextPc)
  );

  assign flagsOut = flags;

endmodule

// File: rtl/flag_branch_checker.sv
module flag_branch_checker #(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busValue,
  input logic              loadFlags,
  input logic [DATA_W-1:0] instr,
  input logic [DATA_W-1:0] pcValue,
  input logic              branchEval,
  input logic              branchTaken,
  input logic [DATA_W-1:0] nextPc,
  input logic [2:0]        flagsOut
);

  logic [2:0] chkMask;
  assign chkMask = instr[PAGE_W+2:PAGE_W];

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(flagsOut) == 1); // R4

  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !loadFlags |=> $stable(flagsOut)); // R3

  AST_LOAD_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (loadFlags && busValue[DATA_W-1]) |=> flagsOut == 3'b100); // R2

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (loadFlags && busValue == '0) |=> flagsOut == 3'b010); // R2

  AST_TARGET_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (nextPc[DATA_W-1:PAGE_W] == pcValue[DATA_W-1:PAGE_W]
                     && nextPc[PAGE_W-1:0] == instr[PAGE_W-1:0])); // R6

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !branchTaken |-> nextPc == DATA_W'(pcValue + DATA_W'(1))); // R7

  AST_MASK_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (branchEval && chkMask == 3'b000) |-> !branchTaken); // R8

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (branchEval && chkMask == 3'b111) |-> branchTaken); // R8

  AST_NO_EVAL: assert property (@(posedge clk) disable iff (!rstN)
    !branchEval |-> !branchTaken); // R9

endmodule

bind flag_branch_resolver flag_branch_checker #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .busValue    (busValue),
  .loadFlags   (loadFlags),
  .instr       (instr),
  .pcValue     (pcValue),
  .branchEval  (branchEval),
  .branchTaken (branchTaken),
  .nextPc      (nextPc),
  .flagsOut    (flagsOut)
);

// File: tb/sim_flag_branch_resolver.sv
module sim_flag_branch_resolver;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busValue = '0;
  logic        loadFlags = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pcValue = '0;
  logic        branchEval = 1'b0;
  logic        branchTaken;
  logic [15:0] nextPc;
  logic [2:0]  flagsOut;

  int vectors = 0;
  int fails = 0;
  logic [2:0] modelFlags = 3'b010;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flag_branch_resolver u0 (
    .clk(clk), .rstN(rstN), .busValue(busValue), .loadFlags(loadFlags),
    .instr(instr), .pcValue(pcValue), .branchEval(branchEval),
    .branchTaken(branchTaken), .nextPc(nextPc), .flagsOut(flagsOut)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] classify(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // R2, R4: load a bus value and check the flags one edge later
  task automatic loadBus(input logic [15:0] v);
    @(negedge clk);
    busValue  = v;
    loadFlags = 1'b1;
    @(negedge clk);
    loadFlags  = 1'b0;
    modelFlags = classify(v);
    #1;
    check(flagsOut == modelFlags, "R2", 32'(flagsOut), 32'(modelFlags));
    check($countones(flagsOut) == 1, "R4", 32'(flagsOut), 32'(modelFlags));
  endtask

  // R5..R9: all masks, strobe on and off
  task automatic sweepBranch(input logic [15:0] pc, input logic [8:0] offs);
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        logic        expTaken;
        logic [15:0] expPc;
        instr      = {4'b0000, 3'(m), offs};
        pcValue    = pc;
        branchEval = 1'(e);
        #1;
        expTaken = (e == 1) && ((3'(m) & modelFlags) != 3'b000);
        expPc    = expTaken ? {pc[15:9], offs} : 16'(pc + 16'd1);
        if (e == 0) begin
          check(branchTaken == 1'b0, "R9", 32'(branchTaken), 32'h0);
          check(nextPc == 16'(pc + 16'd1), "R9", 32'(nextPc), 32'(16'(pc + 16'd1)));
        end else begin
          check(branchTaken == expTaken, "R5", 32'(branchTaken), 32'(expTaken));
          if (m == 0) check(branchTaken == 1'b0, "R8", 32'(branchTaken), 32'h0);
          if (m == 7) check(branchTaken == 1'b1, "R8", 32'(branchTaken), 32'h1);
          if (expTaken) check(nextPc == expPc, "R6", 32'(nextPc), 32'(expPc));
          else          check(nextPc == expPc, "R7", 32'(nextPc), 32'(expPc));
        end
      end
    end
    branchEval = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    busValue = 16'h8001;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(flagsOut == 3'b010, "R1", 32'(flagsOut), 32'h2);
    modelFlags = 3'b010;
    sweepBranch(16'h3B24, 9'h0A7);

    // sign boundaries and specials
    loadBus(16'h0000); sweepBranch(16'hFFFF, 9'h1FF);
    loadBus(16'h7FFF); sweepBranch(16'hFFFF, 9'h000);
    loadBus(16'h8000); sweepBranch(16'h0000, 9'h155);
    loadBus(16'hFFFF); sweepBranch(16'h3DFF, 9'h123);
    loadBus(16'h0001); sweepBranch(16'h01FF, 9'h0AA);

    for (int i = 0; i < 64; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h0413) ^ 16'(i << 10);
      if (i % 7 == 3) v = 16'h0000;
      loadBus(v);
      sweepBranch(v ^ 16'h5A5A, v[8:0] ^ 9'h1A5);
    end

    // R3: bus changes without the load strobe leave the flags alone
    loadBus(16'h0042);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      busValue = (i % 2 == 0) ? 16'h0000 : 16'h9000;
      @(negedge clk);
      #1;
      check(flagsOut == 3'b001, "R3", 32'(flagsOut), 32'h1);
    end

    // R10: branch in the load cycle sees the old flags
    loadBus(16'h0000);
    @(negedge clk);
    busValue   = 16'h8000;
    loadFlags  = 1'b1;
    instr      = {4'b0000, 3'b010, 9'h033};
    pcValue    = 16'h3C10;
    branchEval = 1'b1;
    #1;
    check(branchTaken == 1'b1, "R10", 32'(branchTaken), 32'h1);
    check(nextPc == 16'h3C33, "R10", 32'(nextPc), 32'h3C33);
    @(negedge clk);
    loadFlags = 1'b0;
    #1;
    check(flagsOut == 3'b100, "R10", 32'(flagsOut), 32'h4);
    check(branchTaken == 1'b0, "R10", 32'(branchTaken), 32'h0);
    check(nextPc == 16'h3C11, "R10", 32'(nextPc), 32'h3C11);
    branchEval = 1'b0;

    @(negedge clk);
    finishRun();
  end

endmodule